// File: doc/BRIEF.md
# Double-precision to 32-bit integer wrapping converter

This unit turns a 64-bit IEEE-754 double into a signed 32-bit integer. The conversion always truncates toward zero, whatever rounding mode the rest of the machine uses. A value too large for 32 bits is not clamped: the result is the low 32 bits of the two's-complement truncated integer, so it wraps modulo 2^32. The 32-bit result is returned sign-extended to 64 bits. Two exception flags come with it, placed in a five-bit accrued-flag field: one for a lost fraction and one for an invalid operation.

Operands arrive on a valid/ready stream and results leave on another. The unit is a single register stage. A beat is accepted when `in_valid` and `in_ready` are both high, and its result appears on the output one clock later. `in_ready` is high whenever the output register is empty or the consumer takes the current result in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new operand is accepted. A synchronous reset empties the stage.

Top module: `d2i_mod_conv`

## Requirements
- R1: An operand with exponent field (bits 62:52) zero and fraction field (bits 51:0) zero, of either sign (bit 63), gives result 0 and no flag.
- R2: An operand with exponent field zero and a nonzero fraction gives result 0, and only the inexact flag is set.
- R3: An operand with exponent field all ones (infinity or NaN, either sign) gives result 0, and only the invalid flag is set.
- R4: A normal operand whose truncated value fits in signed 32 bits gives that value. Inexact is set exactly when some nonzero fraction bits were discarded.
- R5: A normal operand with magnitude below 1, including those whose alignment right shift is 64 or more, gives 0 with only inexact set.
- R6: A negative operand gives the two's complement of its truncated magnitude. For example, -2.5 gives 0xFFFFFFFE.
- R7: If the truncated value lies outside [-2^31, 2^31-1], the result is that value modulo 2^32 and invalid is set. -2^31 and -2^31-0.5 both count as in range.
- R8: Inexact and invalid are never set together. When a value is out of range and also has discarded fraction bits, only invalid is reported.
- R9: Bits 63:32 of `out_res` equal bit 31. In `out_flags`, bit 4 is invalid, bit 0 is inexact, and bits 3:1 are zero.
- R10: An operand accepted in one cycle is presented on the output after the next rising edge. `in_ready` equals `!out_valid || out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, `out_res` and `out_flags` hold their values, and an offered operand is not taken.
- R12: A synchronous reset drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Stage can take an operand this cycle |
| in_op | input | 64 | IEEE-754 double operand |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 64 | Wrapped 32-bit integer, sign-extended |
| out_flags | output | 5 | Accrued-flag field: bit 4 invalid, bit 0 inexact |

## Verification
The bench builds the converter with its default parameters: an 11-bit exponent, a 52-bit fraction, a 32-bit integer and a 64-bit output. With these values every alignment regime of a real double can be reached. This covers right shifts past the whole significand, exact left shifts, left shifts that push every significand bit out of the 32-bit window, and the wrap boundary at 2^31 and 2^32 for both signs. Directed steps add reset, a stall held over several cycles with a second operand offered, and release of that stall.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
  localparam int FLAG_W = 5;
  localparam int FLG_NV = 4;
  localparam int FLG_NX = 0;

  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_SUB  = 2'd1,
    K_NORM = 2'd2,
    K_SPEC = 2'd3
  } d2i_kind_e;
endpackage

// File: rtl/d2i_unpack.sv
module d2i_unpack
  import d2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sign,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W-1:0]     frac,
  output d2i_kind_e             kind
);
  localparam int OP_W = EXP_W + FRAC_W + 1;

  assign sign = op[OP_W-1];
  assign expo = op[OP_W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];

  always_comb begin
    if (expo == '0)
      kind = (frac == '0) ? K_ZERO : K_SUB;
    else if (&expo)
      kind = K_SPEC;
    else
      kind = K_NORM;
  end
endmodule

// File: rtl/d2i_align.sv
module d2i_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RES_W  = 32
) (
  input  logic              sign,
  input  logic [EXP_W-1:0]  expo,
  input  logic [FRAC_W-1:0] frac,
  output logic [RES_W-1:0]  mag,
  output logic              sticky,
  output logic              oor
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] shl;
  logic [SIG_W-1:0] shr;
  logic [SIG_W-1:0] low_mask;
  logic [31:0]      ls_amt;
  logic [31:0]      rs_amt;
  int               ue;

  assign sig = {1'b1, frac};

  always_comb begin
    ue       = int'({1'b0, expo}) - BIAS;
    ls_amt   = '0;
    rs_amt   = '0;
    if (ue >= FRAC_W) ls_amt = $unsigned(ue - FRAC_W);
    else              rs_amt = $unsigned(FRAC_W - ue);
    shl      = sig << ls_amt;
    shr      = sig >> rs_amt;
    low_mask = ~({SIG_W{1'b1}} << rs_amt);
    if (ue >= FRAC_W) begin
      mag    = shl[RES_W-1:0];
      sticky = 1'b0;
    end else begin
      mag    = shr[RES_W-1:0];
      sticky = |(sig & low_mask);
    end
    // Range check on the integer part: 2^(RES_W-1) fits only when negative
    if (ue >= RES_W)
      oor = 1'b1;
    else if (ue == RES_W - 1)
      oor = !(sign && (frac[FRAC_W-1 -: RES_W-1] == '0));
    else
      oor = 1'b0;
  end
endmodule

// File: rtl/d2i_pack.sv
module d2i_pack
  import d2i_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  d2i_kind_e          kind,
  input  logic               sign,
  input  logic [RES_W-1:0]   mag,
  input  logic               sticky,
  input  logic               oor,
  output logic [RES_W-1:0]   res,
  output logic [FLAG_W-1:0]  flags
);
  logic nv;
  logic nx;

  always_comb begin
    res = '0;
    nv  = 1'b0;
    nx  = 1'b0;
    unique case (kind)
      K_ZERO: ;
      K_SUB:  nx = 1'b1;
      K_SPEC: nv = 1'b1;
      K_NORM: begin
        res = sign ? (~mag + 1'b1) : mag;
        nv  = oor;
        nx  = sticky && !oor;
      end
      default: ;
    endcase
    flags         = '0;
    flags[FLG_NV] = nv;
    flags[FLG_NX] = nx;
  end
endmodule

// File: rtl/d2i_mod_conv.sv
module d2i_mod_conv
  import d2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int RES_W  = 32,
  parameter int OUT_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [EXP_W+FRAC_W:0]      in_op,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [OUT_W-1:0]           out_res,
  output logic [FLAG_W-1:0]          out_flags
);
  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  d2i_kind_e         kind;
  logic [RES_W-1:0]  mag;
  logic              sticky;
  logic              oor;
  logic [RES_W-1:0]  res_c;
  logic [FLAG_W-1:0] flags_c;
  logic              take;

  d2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .op(in_op), .sign(sign), .expo(expo), .frac(frac), .kind(kind)
  );

  d2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_align (
    .sign(sign), .expo(expo), .frac(frac),
    .mag(mag), .sticky(sticky), .oor(oor)
  );

  d2i_pack #(.RES_W(RES_W)) u_pack (
    .kind(kind), .sign(sign), .mag(mag), .sticky(sticky), .oor(oor),
    .res(res_c), .flags(flags_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_res   <= {{(OUT_W-RES_W){res_c[RES_W-1]}}, res_c};
        out_flags <= flags_c;
      end
    end
  end
endmodule

// File: rtl/d2i_mod_conv_chk.sv
module d2i_mod_conv_chk #(
  parameter int EXP_W = 11,
  parameter int OUT_W = 64,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [EXP_W-1:0] in_exp,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_res,
  input logic [4:0]       out_flags
);
  // R3
  a_r3_special_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (&in_exp)) |=> (out_res == '0 && out_flags == 5'b10000));
  // R8
  a_r8_flag_excl: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_flags[4] && out_flags[0]));
  // R9
  a_r9_sext: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_res[OUT_W-1:RES_W] == {(OUT_W-RES_W){out_res[RES_W-1]}}));
  a_r9_spare_flags: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags[3:1] == 3'b000));
  // R10
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_flags)));
  // R12
  a_r12_reset: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind d2i_mod_conv d2i_mod_conv_chk #(.EXP_W(EXP_W), .OUT_W(OUT_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_exp(in_op[EXP_W+FRAC_W-1 -: EXP_W]), .out_valid(out_valid),
  .out_ready(out_ready), .out_res(out_res), .out_flags(out_flags)
);

// File: tb/tb_d2i_mod_conv.sv
module tb_d2i_mod_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;

  // operand, expected 32-bit result, expected flags, requirement number
  localparam logic [63:0] V_OP [NVEC] = '{
    64'h0000000000000000, // R1 +0
    64'h8000000000000000, // R1 -0
    64'h0000000000000001, // R2 smallest subnormal
    64'h000FFFFFFFFFFFFF, // R2 largest subnormal
    64'h7FF0000000000000, // R3 +inf
    64'hFFF0000000000000, // R3 -inf
    64'h7FF8000000000000, // R3 NaN
    64'h3FF0000000000000, // R4 1.0
    64'h3FF8000000000000, // R4 1.5
    64'h4059300000000000, // R4 100.75
    64'h3FFFFFFFFFFFFFFF, // R4 just under 2
    64'h41DFFFFFFFC00000, // R4 2^31-1
    64'h3FE0000000000000, // R5 0.5
    64'h39B0000000000000, // R5 2^-100
    64'hBFF0000000000000, // R6 -1.0
    64'hC004000000000000, // R6 -2.5
    64'hC008000000000000, // R6 -3.0
    64'hC1E0000000000000, // R7 -2^31
    64'hC1E0000000100000, // R7 -2^31-0.5
    64'hC1E0000000200000, // R7 -2^31-1
    64'h41E0000000000000, // R7 2^31
    64'h41F0000000000000, // R7 2^32
    64'h41F0000000500000, // R7 2^32+5
    64'hC1F0000000500000, // R7 -(2^32+5)
    64'h4340000000000000, // R7 2^53
    64'h4450000000000000, // R7 2^70
    64'h7FEFFFFFFFFFFFFF, // R7 max finite
    64'h41F0000000580000  // R8 2^32+5.5
  };
  localparam logic [31:0] V_RES [NVEC] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h1, 32'h1, 32'h64, 32'h1, 32'h7FFFFFFF,
    32'h0, 32'h0,
    32'hFFFFFFFF, 32'hFFFFFFFE, 32'hFFFFFFFD,
    32'h80000000, 32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h0,
    32'h5, 32'hFFFFFFFB, 32'h0, 32'h0, 32'h0,
    32'h5
  };
  localparam logic [4:0] V_FL [NVEC] = '{
    5'h00, 5'h00, 5'h01, 5'h01, 5'h10, 5'h10, 5'h10,
    5'h00, 5'h01, 5'h01, 5'h01, 5'h00,
    5'h01, 5'h01,
    5'h00, 5'h01, 5'h00,
    5'h00, 5'h01, 5'h10, 5'h10, 5'h10,
    5'h10, 5'h10, 5'h10, 5'h10, 5'h10,
    5'h10
  };
  localparam int V_REQ [NVEC] = '{
    1, 1, 2, 2, 3, 3, 3, 4, 4, 4, 4, 4, 5, 5, 6, 6, 6,
    7, 7, 7, 7, 7, 7, 7, 7, 7, 7, 8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_res;
  logic [4:0]  out_flags;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  d2i_mod_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_flags(out_flags)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R10 ready when empty", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      send(V_OP[i]);
      chk($sformatf("R%0d valid v%0d", V_REQ[i], i), {63'd0, out_valid}, 64'd1);
      chk($sformatf("R%0d res v%0d", V_REQ[i], i), out_res,
          {{32{V_RES[i][31]}}, V_RES[i]});
      chk($sformatf("R%0d flags v%0d", V_REQ[i], i), {59'd0, out_flags},
          {59'd0, V_FL[i]});
    end

    // R10: without a new beat the output empties on the next edge
    @(posedge clk);
    #1;
    chk("R10 empties", {63'd0, out_valid}, 64'd0);

    // R11: stall with a second operand offered
    @(negedge clk);
    out_ready = 1'b0;
    send(64'hC004000000000000);
    chk("R11 stalled result", out_res, 64'hFFFFFFFFFFFFFFFE);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 64'h7FF0000000000000;
    #1;
    chk("R11 ready low", {63'd0, in_ready}, 64'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 held res", out_res, 64'hFFFFFFFFFFFFFFFE);
    chk("R11 held flags", {59'd0, out_flags}, 64'h01);
    chk("R11 held valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk("R11 released res", out_res, 64'd0);
    chk("R11 released flags", {59'd0, out_flags}, 64'h10);

    // R12: reset while holding a result
    @(negedge clk);
    out_ready = 1'b0;
    send(64'h3FF0000000000000);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R12 reset clears", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule